// File: doc/BRIEF.md
# Breakpoint and Trace Event Unit

This unit sits beside the retire stage of a small processor core and decides, for each instruction that completes, whether control must pass to a debug handler. It has three sources of debug events. The first is a pair of programmable instruction-address comparators. The second is a pair of reserved software-breakpoint opcodes. The third is a set of trace conditions: single step, call, return and branch.

When an event is raised, the unit pulses a request carrying a cause code and asserts a stall line. The core must treat the stall line as a freeze. No further instruction is accepted until the handler reports completion with a one-cycle done strobe, after which execution continues with the next instruction. Trace events are evaluated on the retire stream, so the traced instruction has always completed before its event appears.

Configuration uses a small write port with a two-bit register select. Select 0 and select 1 load the two comparator addresses. Select 2 loads the comparator enables. Select 3 loads the trace-control word.

Top module: `dbg_event_unit`

## Requirements
- R1: After a synchronous reset, `stall`, `evt_req` and `evt_cause` are 0, and all comparator enables and trace enables are cleared, so no retire raises an event except a software breakpoint.
- R2: A write with `cfg_sel`=0 or 1 loads comparator 0 or 1 with `cfg_wdata[AW-1:0]`. A write with `cfg_sel`=2 sets comparator enables from bit 0 (comparator 0) and bit 1 (comparator 1). A comparator whose enable is clear never raises an event, even when the address matches.
- R3: An accepted retire whose `ret_ip` equals an enabled comparator raises an event on the following cycle. The cause is 1 for comparator 0 and 2 for comparator 1.
- R4: An accepted retire whose `ret_opcode` equals either `SWBP_OP_A` or `SWBP_OP_B` raises an event with cause 3, whatever the enables hold.
- R5: A write with `cfg_sel`=3 loads the trace-control word. Its bits select the trace kinds: bit 0 single step (any retire, cause 4), bit 1 call (cause 5), bit 2 return (cause 6) and bit 3 branch (cause 7). The remaining bits are reserved and have no effect. The event follows the retire of the traced instruction.
- R6: When several causes apply to one retire, exactly one event is reported. The priority order is comparator 0, then comparator 1, then software breakpoint, then call, then return, then branch, then single step.
- R7: While `stall` is high, `ret_valid` is ignored: no event is raised and no instruction is accepted.
- R8: `stall` rises together with `evt_req` and stays high until `hdl_done` is sampled high. It is low on the following cycle. An `hdl_done` pulse while `stall` is low has no effect.
- R9: `evt_req` is a single-cycle pulse whenever it is high. `evt_cause` is nonzero and keeps its value until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_ip | input | AW | Address of the retiring instruction |
| ret_opcode | input | OPW | Opcode of the retiring instruction |
| ret_is_call | input | 1 | Retiring instruction is a call |
| ret_is_ret | input | 1 | Retiring instruction is a return |
| ret_is_branch | input | 1 | Retiring instruction is a taken branch |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | DW | Configuration write data |
| hdl_done | input | 1 | Handler has finished |
| evt_req | output | 1 | Debug event request pulse |
| evt_cause | output | 3 | Cause code of the latest event |
| stall | output | 1 | Retirement frozen while the handler runs |

## Verification
The bench builds the unit with a 16-bit address, 8-bit opcodes and the software-breakpoint opcodes set to 0x3C and 0x3D. With a narrow address it is cheap to place probe addresses next to a comparator value, so a match can be told apart from an off-by-one near miss. The two adjacent opcodes check that each opcode is decoded separately. A behavioural model predicts the request, cause and stall on every cycle. This comparison covers the windows where a retire, a configuration write or a done strobe arrives during a stall.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_HWBP0  = 3'd1,
    CZ_HWBP1  = 3'd2,
    CZ_SOFT   = 3'd3,
    CZ_STEP   = 3'd4,
    CZ_CALL   = 3'd5,
    CZ_RET    = 3'd6,
    CZ_BRANCH = 3'd7
  } dbg_cause_e;

  // number of address comparators
  localparam int NUM_BP = 2;

  // trace-control bit positions
  localparam int TC_STEP   = 0;
  localparam int TC_CALL   = 1;
  localparam int TC_RET    = 2;
  localparam int TC_BRANCH = 3;
  localparam int TC_USED   = 4;

  // configuration selects
  localparam logic [1:0] SEL_BP0   = 2'd0;
  localparam logic [1:0] SEL_BP1   = 2'd1;
  localparam logic [1:0] SEL_BPEN  = 2'd2;
  localparam logic [1:0] SEL_TRACE = 2'd3;

endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [AW-1:0]     probe_ip,
  output logic [NUM_BP-1:0] hit
);

  logic [NUM_BP-1:0] bp_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_en <= '0;
    end else if (cfg_we && cfg_sel == SEL_BPEN) begin
      bp_en <= cfg_wdata[NUM_BP-1:0];
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    logic [AW-1:0] bp_addr;

    always_ff @(posedge clk) begin
      if (rst) begin
        bp_addr <= '0;
      end else if (cfg_we && cfg_sel == 2'(g)) begin
        bp_addr <= cfg_wdata[AW-1:0];
      end
    end

    assign hit[g] = bp_en[g] && (probe_ip == bp_addr);
  end

endmodule

// File: rtl/dbg_trace_ctl.sv
module dbg_trace_ctl
  import dbg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic               is_call,
  input  logic               is_ret,
  input  logic               is_branch,
  output logic [TC_USED-1:0] trace_hit
);

  // only the defined bits of the trace-control word are stored
  logic [TC_USED-1:0] tc_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_en <= '0;
    end else if (cfg_we && cfg_sel == SEL_TRACE) begin
      tc_en <= cfg_wdata[TC_USED-1:0];
    end
  end

  always_comb begin
    trace_hit            = '0;
    trace_hit[TC_STEP]   = tc_en[TC_STEP];
    trace_hit[TC_CALL]   = tc_en[TC_CALL] && is_call;
    trace_hit[TC_RET]    = tc_en[TC_RET] && is_ret;
    trace_hit[TC_BRANCH] = tc_en[TC_BRANCH] && is_branch;
  end

endmodule

// File: rtl/dbg_evt_arb.sv
module dbg_evt_arb
  import dbg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ret_valid,
  input  logic [NUM_BP-1:0]  bp_hit,
  input  logic               sw_hit,
  input  logic [TC_USED-1:0] trace_hit,
  input  logic               hdl_done,
  output logic               evt_req,
  output dbg_cause_e         evt_cause,
  output logic               stall
);

  dbg_cause_e win;

  // later assignments override earlier ones: highest priority last
  always_comb begin
    win = CZ_NONE;
    if (trace_hit[TC_STEP])   win = CZ_STEP;
    if (trace_hit[TC_BRANCH]) win = CZ_BRANCH;
    if (trace_hit[TC_RET])    win = CZ_RET;
    if (trace_hit[TC_CALL])   win = CZ_CALL;
    if (sw_hit)               win = CZ_SOFT;
    if (bp_hit[1])            win = CZ_HWBP1;
    if (bp_hit[0])            win = CZ_HWBP0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_req   <= 1'b0;
      evt_cause <= CZ_NONE;
      stall     <= 1'b0;
    end else begin
      evt_req <= 1'b0;
      if (stall && hdl_done) stall <= 1'b0;
      if (ret_valid && !stall && win != CZ_NONE) begin
        evt_req   <= 1'b1;
        evt_cause <= win;
        stall     <= 1'b1;
      end
    end
  end

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    evt_req |=> !evt_req);
  p_cause_known_r9: assert property (@(posedge clk) disable iff (rst)
    evt_req |-> evt_cause != CZ_NONE);
  p_cause_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !evt_req |=> (evt_req || $stable(evt_cause)));
  p_req_stalls_r8: assert property (@(posedge clk) disable iff (rst)
    evt_req |-> stall);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && !hdl_done) |=> stall);
  p_stall_release_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && hdl_done) |=> !stall);
  p_quiet_handler_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !evt_req);

endmodule

// File: rtl/dbg_event_unit.sv
module dbg_event_unit
  import dbg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OPW = 8,
  parameter logic [OPW-1:0] SWBP_OP_A = 8'hF0,
  parameter logic [OPW-1:0] SWBP_OP_B = 8'hF1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ret_valid,
  input  logic [AW-1:0]  ret_ip,
  input  logic [OPW-1:0] ret_opcode,
  input  logic           ret_is_call,
  input  logic           ret_is_ret,
  input  logic           ret_is_branch,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           hdl_done,
  output logic           evt_req,
  output logic [2:0]     evt_cause,
  output logic           stall
);

  logic [NUM_BP-1:0]  bp_hit;
  logic [TC_USED-1:0] trace_hit;
  logic               sw_hit;
  dbg_cause_e         cause_q;

  assign sw_hit = (ret_opcode == SWBP_OP_A) || (ret_opcode == SWBP_OP_B);

  dbg_bp_match #(.AW(AW), .DW(DW)) u_bp (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .probe_ip  (ret_ip),
    .hit       (bp_hit)
  );

  dbg_trace_ctl #(.DW(DW)) u_trc (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .is_call   (ret_is_call),
    .is_ret    (ret_is_ret),
    .is_branch (ret_is_branch),
    .trace_hit (trace_hit)
  );

  dbg_evt_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .ret_valid (ret_valid),
    .bp_hit    (bp_hit),
    .sw_hit    (sw_hit),
    .trace_hit (trace_hit),
    .hdl_done  (hdl_done),
    .evt_req   (evt_req),
    .evt_cause (cause_q),
    .stall     (stall)
  );

  assign evt_cause = cause_q;

  p_soft_event_r4: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !stall && sw_hit && bp_hit == '0)
      |=> (evt_req && evt_cause == 3'd3));
  p_bp0_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !stall && bp_hit[0]) |=> (evt_req && evt_cause == 3'd1));

endmodule

// File: tb/sim_dbg_event_unit.sv
module sim_dbg_event_unit;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int OPW = 8;
  localparam logic [OPW-1:0] OPA = 8'h3C;
  localparam logic [OPW-1:0] OPB = 8'h3D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ret_valid = 1'b0;
  logic [AW-1:0] ret_ip = '0;
  logic [OPW-1:0] ret_opcode = '0;
  logic ret_is_call = 1'b0, ret_is_ret = 1'b0, ret_is_branch = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic hdl_done = 1'b0;
  logic evt_req, stall;
  logic [2:0] evt_cause;

  int vectors = 0;
  int fails = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  dbg_event_unit #(.AW(AW), .DW(DW), .OPW(OPW), .SWBP_OP_A(OPA), .SWBP_OP_B(OPB)) u0 (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_ip(ret_ip),
    .ret_opcode(ret_opcode), .ret_is_call(ret_is_call), .ret_is_ret(ret_is_ret),
    .ret_is_branch(ret_is_branch), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hdl_done(hdl_done), .evt_req(evt_req),
    .evt_cause(evt_cause), .stall(stall)
  );

  // behavioural reference model
  logic [AW-1:0] m_addr [2];
  logic [1:0] m_en;
  logic [31:0] m_tc;
  logic m_req, m_stall;
  int m_cause;

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_tc <= 0; m_req <= 0; m_stall <= 0; m_cause <= 0;
      m_addr[0] <= 0; m_addr[1] <= 0;
    end else begin
      int c;
      c = 0;
      if (ret_valid && !m_stall) begin
        if (m_tc[0]) c = 4;
        if (m_tc[3] && ret_is_branch) c = 7;
        if (m_tc[2] && ret_is_ret) c = 6;
        if (m_tc[1] && ret_is_call) c = 5;
        if (ret_opcode == OPA || ret_opcode == OPB) c = 3;
        if (m_en[1] && ret_ip == m_addr[1]) c = 2;
        if (m_en[0] && ret_ip == m_addr[0]) c = 1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_addr[0] <= cfg_wdata[AW-1:0];
          2'd1: m_addr[1] <= cfg_wdata[AW-1:0];
          2'd2: m_en <= cfg_wdata[1:0];
          default: m_tc <= cfg_wdata;
        endcase
      end
      m_req <= (c != 0);
      if (m_stall && hdl_done) m_stall <= 0;
      if (c != 0) begin
        m_cause <= c;
        m_stall <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (evt_req !== m_req || stall !== m_stall || int'(evt_cause) !== m_cause) begin
        fails++;
        $display("FAIL %s model: req/stall/cause got %0b/%0b/%0d expected %0b/%0b/%0d",
                 cur_tag, evt_req, stall, evt_cause, m_req, m_stall, m_cause);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic retire(input logic [AW-1:0] ip, input logic [OPW-1:0] op,
                        input logic c, input logic r, input logic b);
    ret_valid = 1; ret_ip = ip; ret_opcode = op;
    ret_is_call = c; ret_is_ret = r; ret_is_branch = b;
    @(negedge clk);
    ret_valid = 0; ret_is_call = 0; ret_is_ret = 0; ret_is_branch = 0;
    ret_opcode = 8'h00;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic done();
    hdl_done = 1;
    @(negedge clk);
    hdl_done = 0;
  endtask

  // expect an event from the retire just issued, then release the handler
  task automatic expect_evt(input string tag, input int cause);
    chk(tag, int'(evt_req), 1);
    chk(tag, int'(evt_cause), cause);
    chk(tag, int'(stall), 1);
    done();
    chk(tag, int'(stall), 0);
  endtask

  task automatic expect_none(input string tag);
    chk(tag, int'(evt_req), 0);
    chk(tag, int'(stall), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    cur_tag = "R1";
    chk("R1", int'(evt_req), 0);
    chk("R1", int'(stall), 0);
    chk("R1", int'(evt_cause), 0);
    retire(16'h0000, 8'h01, 1, 1, 1);
    expect_none("R1");

    // R2: disabled comparator never fires
    cur_tag = "R2";
    wr(2'd0, 32'h0000_1234);
    wr(2'd1, 32'h0000_0BEE);
    retire(16'h1234, 8'h01, 0, 0, 0);
    expect_none("R2");
    wr(2'd2, 32'h0000_0002);
    retire(16'h1234, 8'h01, 0, 0, 0);
    expect_none("R2");

    // R3: address matches
    cur_tag = "R3";
    wr(2'd2, 32'h0000_0003);
    retire(16'h1233, 8'h01, 0, 0, 0);
    expect_none("R3");
    retire(16'h1234, 8'h01, 0, 0, 0);
    expect_evt("R3", 1);
    retire(16'h0BEE, 8'h01, 0, 0, 0);
    expect_evt("R3", 2);

    // R9: pulse and hold of cause
    cur_tag = "R9";
    retire(16'h1234, 8'h01, 0, 0, 0);
    chk("R9", int'(evt_req), 1);
    @(negedge clk);
    chk("R9", int'(evt_req), 0);
    chk("R9", int'(evt_cause), 1);

    // R7: retires ignored while stalled
    cur_tag = "R7";
    retire(16'h1234, OPA, 1, 0, 0);
    chk("R7", int'(evt_req), 0);
    chk("R7", int'(stall), 1);
    chk("R7", int'(evt_cause), 1);

    // R8: release and idle done
    cur_tag = "R8";
    repeat (3) @(negedge clk);
    chk("R8", int'(stall), 1);
    done();
    chk("R8", int'(stall), 0);
    done();
    chk("R8", int'(stall), 0);
    chk("R8", int'(evt_req), 0);

    // R4: software breakpoints with comparators off
    cur_tag = "R4";
    wr(2'd2, 32'h0);
    retire(16'h1234, OPA, 0, 0, 0);
    expect_evt("R4", 3);
    retire(16'h0040, OPB, 0, 0, 0);
    expect_evt("R4", 3);
    retire(16'h0042, 8'h3E, 0, 0, 0);
    expect_none("R4");

    // R5: trace kinds
    cur_tag = "R5";
    wr(2'd3, 32'hFFFF_FFF0);
    retire(16'h0050, 8'h01, 1, 1, 1);
    expect_none("R5");
    wr(2'd3, 32'h0000_0002);
    retire(16'h0050, 8'h01, 0, 1, 1);
    expect_none("R5");
    retire(16'h0051, 8'h01, 1, 0, 0);
    expect_evt("R5", 5);
    wr(2'd3, 32'h0000_0004);
    retire(16'h0052, 8'h01, 0, 1, 0);
    expect_evt("R5", 6);
    wr(2'd3, 32'h0000_0008);
    retire(16'h0053, 8'h01, 0, 0, 1);
    expect_evt("R5", 7);
    wr(2'd3, 32'h0000_0001);
    retire(16'h0054, 8'h01, 0, 0, 0);
    expect_evt("R5", 4);
    retire(16'h0055, 8'h01, 0, 0, 0);
    expect_evt("R5", 4);

    // R6: priority
    cur_tag = "R6";
    wr(2'd3, 32'h0000_000F);
    wr(2'd2, 32'h0000_0003);
    wr(2'd1, 32'h0000_1234);
    retire(16'h1234, OPA, 1, 1, 1);
    expect_evt("R6", 1);
    wr(2'd2, 32'h0000_0002);
    retire(16'h1234, OPA, 1, 1, 1);
    expect_evt("R6", 2);
    retire(16'h0060, OPB, 1, 1, 1);
    expect_evt("R6", 3);
    retire(16'h0061, 8'h01, 1, 1, 1);
    expect_evt("R6", 5);
    retire(16'h0062, 8'h01, 0, 1, 1);
    expect_evt("R6", 6);
    retire(16'h0063, 8'h01, 0, 0, 1);
    expect_evt("R6", 7);

    // back-to-back retire right after release
    cur_tag = "R8";
    retire(16'h0064, 8'h01, 0, 0, 0);
    chk("R8", int'(evt_cause), 4);
    hdl_done = 1;
    ret_valid = 1; ret_ip = 16'h0065;
    @(negedge clk);
    hdl_done = 0; ret_valid = 0;
    chk("R8", int'(stall), 0);
    chk("R8", int'(evt_req), 0);
    retire(16'h0066, 8'h01, 0, 0, 0);
    expect_evt("R8", 4);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule